// File: doc/BRIEF.md
# Instruction Address Sequencer with Run-Time Addressing Modes

This block holds the instruction address of a processor's status word and produces its next value each time an instruction retires. On a retiring step it either advances the address by the instruction length (2, 4 or 6 bytes) or, for a conditional branch, loads a target address. The branch is taken when the stored two-bit condition code is one of the values picked by a four-bit mask. A compare result given on the same step sets the new condition code. The branch decision uses the code as it stood before that step.

Two mode bits choose the address width at run time: 24, 31 or 64 bits. In the narrow modes every address bit above the width is forced to zero, so sequential advance wraps inside the active width. The block also drives a failing-instruction address for exception reporting. For most exception codes this is the current address minus the length. For the two translation exception codes it is the current address itself. An illegal mode-bit pair or an illegal length rejects the step and raises a specification flag.

Top module: `insn_addr_seq`

## Requirements
- R1: After reset the address is 0, the condition code is 0 and the specification flag is low.
- R2: A valid step that does not branch, or whose branch is not taken, sets the address to the old address plus the length in bytes.
- R3: A valid step with compare valid sets the condition code from {gt, lt}: equal gives 0, lower gives 1, higher gives 2, both flags give 3. Without compare valid the code is kept.
- R4: A branch is taken when mask bit (3 - cc) is one, so mask bit 3 selects code 0 and mask bit 0 selects code 3. The cc used is the value held before the step.
- R5: Mode bits {ea, ba} decode as 00 = 24-bit, 01 = 31-bit, 11 = 64-bit.
- R6: In 24-bit and 31-bit modes the stored address, whether target or sequential, has every bit at or above the mode width at zero. The highest reachable values are 0xFFFFFF and 0x7FFFFFFF.
- R7: Sequential advance wraps modulo 2 to the power of the current mode width.
- R8: The failing address equals the current address minus the present length, truncated to the current mode width.
- R9: For exception codes 0x10 and 0x11 the failing address equals the current address. Other codes follow R8.
- R10: A step with ea = 1 and ba = 0 raises spec_exc in the same cycle and changes neither the address nor the condition code.
- R11: A step with a length other than 2, 4 or 6 raises spec_exc in the same cycle and changes neither the address nor the condition code.
- R12: With step_en low the address and the condition code hold, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | An instruction retires this cycle |
| ilen | input | 4 | Instruction length in bytes |
| is_branch | input | 1 | Retiring instruction is a conditional branch |
| br_mask | input | 4 | Condition-code selection mask (bit 3 = code 0) |
| br_target | input | 64 | Branch target address |
| cmp_valid | input | 1 | Compare result present, update condition code |
| cmp_lt | input | 1 | First operand lower |
| cmp_gt | input | 1 | First operand higher |
| mode_ea | input | 1 | Extended addressing mode bit |
| mode_ba | input | 1 | Basic addressing mode bit |
| exc_code | input | 8 | Exception code for failing-address rule |
| next_addr | output | 64 | Current instruction address |
| fail_addr | output | 64 | Failing-instruction address |
| cc_out | output | 2 | Current condition code |
| spec_exc | output | 1 | Step rejected: bad mode pair or bad length |

## Verification
The main stepping function runs through a chain of vectors. Each vector starts from the state the previous one left. The chain covers plain advances of each legal length, taken and untaken branches for every condition code, and mode changes between steps. Taken branches whose mask selects a non-current code would show a wrong mask bit order. Steps that combine a compare with a branch show whether the decision uses the old code or the newly set one. High-bit targets and advances across the top of each width show whether truncation and wrap follow the live mode bits. Directed cases then probe the failing address on both sides of the two translation codes, and rejected and idle steps that carry active branch and compare inputs.

// File: rtl/insn_addr_pkg.sv
package insn_addr_pkg;

   localparam int CC_W   = 2;
   localparam int MASK_W = 1 << CC_W;

   typedef enum logic [1:0] {
      AM_24  = 2'd0,
      AM_31  = 2'd1,
      AM_64  = 2'd2,
      AM_BAD = 2'd3
   } amode_e;

endpackage

// File: rtl/amode_decode.sv
module amode_decode
   import insn_addr_pkg::*;
(
   input  logic   ea,
   input  logic   ba,
   output amode_e mode,
   output logic   mode_ok
);

   always_comb begin
      unique case ({ea, ba})
         2'b00:   mode = AM_24;
         2'b01:   mode = AM_31;
         2'b11:   mode = AM_64;
         default: mode = AM_BAD;
      endcase
   end

   assign mode_ok = (mode != AM_BAD);

endmodule

// File: rtl/width_mask.sv
module width_mask
   import insn_addr_pkg::*;
#(
   parameter int ADDR_W    = 64,
   parameter int NARROW_LO = 24,
   parameter int NARROW_HI = 31
) (
   input  amode_e            mode,
   output logic [ADDR_W-1:0] keep
);

   if (NARROW_LO >= NARROW_HI || NARROW_HI >= ADDR_W) begin : g_bad_param
      $error("width_mask: need NARROW_LO < NARROW_HI < ADDR_W");
   end

   logic wide_mid;
   logic wide_top;

   assign wide_mid = (mode != AM_24);
   assign wide_top = (mode == AM_64) || (mode == AM_BAD);

   for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
      if (i < NARROW_LO) begin : g_low
         assign keep[i] = 1'b1;
      end else if (i < NARROW_HI) begin : g_mid
         assign keep[i] = wide_mid;
      end else begin : g_top
         assign keep[i] = wide_top;
      end
   end

endmodule

// File: rtl/cc_branch_eval.sv
module cc_branch_eval
   import insn_addr_pkg::*;
(
   input  logic [CC_W-1:0]   cc,
   input  logic [MASK_W-1:0] sel_mask,
   output logic              take
);

   logic [MASK_W-1:0] hit;

   for (genvar i = 0; i < MASK_W; i++) begin : g_sel
      assign hit[i] = sel_mask[MASK_W-1-i] && (cc == CC_W'(i));
   end

   assign take = |hit;

endmodule

// File: rtl/insn_addr_seq.sv
module insn_addr_seq
   import insn_addr_pkg::*;
#(
   parameter int          ADDR_W     = 64,
   parameter int          NARROW_LO  = 24,
   parameter int          NARROW_HI  = 31,
   parameter int          LEN_W      = 4,
   parameter int          MAX_ILEN   = 6,
   parameter int          EXC_W      = 8,
   parameter logic [7:0]  SEG_XLATE  = 8'h10,
   parameter logic [7:0]  PAGE_XLATE = 8'h11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_en,
   input  logic [LEN_W-1:0]  ilen,
   input  logic              is_branch,
   input  logic [3:0]        br_mask,
   input  logic [ADDR_W-1:0] br_target,
   input  logic              cmp_valid,
   input  logic              cmp_lt,
   input  logic              cmp_gt,
   input  logic              mode_ea,
   input  logic              mode_ba,
   input  logic [EXC_W-1:0]  exc_code,
   output logic [ADDR_W-1:0] next_addr,
   output logic [ADDR_W-1:0] fail_addr,
   output logic [1:0]        cc_out,
   output logic              spec_exc
);

   localparam int PAD_W = ADDR_W - LEN_W;

   if (MASK_W != 4) begin : g_bad_mask
      $error("insn_addr_seq: selection mask must be four bits");
   end
   if (MAX_ILEN >= (1 << LEN_W) || EXC_W < 8) begin : g_bad_len
      $error("insn_addr_seq: MAX_ILEN or EXC_W out of range");
   end

   amode_e            mode;
   logic              mode_ok;
   logic [ADDR_W-1:0] keep;
   logic              take_hit;
   logic              len_ok;
   logic              do_step;
   logic              take;
   logic              xlate_exc;
   logic [ADDR_W-1:0] len_ext;
   logic [ADDR_W-1:0] seq_addr;
   logic [ADDR_W-1:0] raw_addr;
   logic [ADDR_W-1:0] addr_q;
   logic [CC_W-1:0]   cc_q;

   amode_decode u_mode (
      .ea      (mode_ea),
      .ba      (mode_ba),
      .mode    (mode),
      .mode_ok (mode_ok)
   );

   width_mask #(
      .ADDR_W    (ADDR_W),
      .NARROW_LO (NARROW_LO),
      .NARROW_HI (NARROW_HI)
   ) u_mask (
      .mode (mode),
      .keep (keep)
   );

   cc_branch_eval u_br (
      .cc       (cc_q),
      .sel_mask (br_mask),
      .take     (take_hit)
   );

   assign len_ok   = (ilen != '0) && !ilen[0] && (ilen <= LEN_W'(MAX_ILEN));
   assign spec_exc = step_en && !(mode_ok && len_ok);
   assign do_step  = step_en && mode_ok && len_ok;
   assign take     = is_branch && take_hit;

   assign len_ext  = {{PAD_W{1'b0}}, ilen};
   assign seq_addr = addr_q + len_ext;
   assign raw_addr = take ? br_target : seq_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         cc_q   <= '0;
      end else if (do_step) begin
         addr_q <= raw_addr & keep;
         if (cmp_valid) begin
            cc_q <= {cmp_gt, cmp_lt};
         end
      end
   end

   assign xlate_exc = (exc_code[7:0] == SEG_XLATE) || (exc_code[7:0] == PAGE_XLATE);
   assign fail_addr = xlate_exc ? addr_q : ((addr_q - len_ext) & keep);

   assign next_addr = addr_q;
   assign cc_out    = cc_q;

   assert_hold_idle_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> ($stable(next_addr) && $stable(cc_out)));

   assert_reject_hold_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      spec_exc |=> ($stable(next_addr) && $stable(cc_out)));

   assert_bad_mode_flag_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && mode_ea && !mode_ba) |-> spec_exc);

   assert_seq_step_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !spec_exc && !is_branch && mode_ea && mode_ba)
      |=> (next_addr == $past(next_addr) + $past(len_ext)));

   assert_narrow24_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !spec_exc && !mode_ea && !mode_ba)
      |=> (next_addr[ADDR_W-1:NARROW_LO] == '0));

   assert_cc_equal_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !spec_exc && cmp_valid && !cmp_lt && !cmp_gt) |=> (cc_out == 2'd0));

   assert_fail_xlate_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      ((exc_code == EXC_W'(SEG_XLATE)) || (exc_code == EXC_W'(PAGE_XLATE)))
      |-> (fail_addr == next_addr));

endmodule

// File: tb/insn_addr_seq_bench.sv
`timescale 1ns/1ps
module insn_addr_seq_bench;

   typedef struct packed {
      logic [3:0]  ilen;
      logic        br;
      logic [3:0]  mask;
      logic [63:0] tgt;
      logic        cv;
      logic        lt;
      logic        gt;
      logic        ea;
      logic        ba;
      logic [63:0] exp_addr;
      logic [1:0]  exp_cc;
   } vec_t;

   localparam int NVEC = 14;
   localparam vec_t VECS [NVEC] = '{
      '{4'd2, 1'b0, 4'b0000, 64'h0,                  1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 64'h2,                  2'd0},
      '{4'd4, 1'b0, 4'b0000, 64'h0,                  1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 64'h6,                  2'd1},
      '{4'd6, 1'b1, 4'b0100, 64'h1000,               1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 64'h1000,               2'd2},
      '{4'd4, 1'b1, 4'b1011, 64'h2_0000_0000,        1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 64'h2_0000_0000,        2'd2},
      '{4'd2, 1'b1, 4'b1101, 64'h5555,               1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 64'h2_0000_0002,        2'd3},
      '{4'd2, 1'b1, 4'b0001, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 2'd3},
      '{4'd4, 1'b0, 4'b0000, 64'h0,                  1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 64'h2,                  2'd3},
      '{4'd2, 1'b1, 4'b0001, 64'h1234_5678_FFFF_FFF0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 64'h7FFF_FFF0,          2'd0},
      '{4'd6, 1'b0, 4'b0000, 64'h0,                  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 64'h7FFF_FFF6,          2'd0},
      '{4'd6, 1'b0, 4'b0000, 64'h0,                  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 64'h7FFF_FFFC,          2'd0},
      '{4'd4, 1'b1, 4'b0111, 64'h40,                 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 64'h0,                  2'd0},
      '{4'd2, 1'b1, 4'b1000, 64'hABCD_EF12_34FF_FFFE, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 64'hFF_FFFE,            2'd2},
      '{4'd4, 1'b0, 4'b0000, 64'h0,                  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h2,                  2'd2},
      '{4'd6, 1'b1, 4'b0111, 64'h0123_4566,          1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h23_4566,            2'd2}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        step_en;
   logic [3:0]  ilen;
   logic        is_branch;
   logic [3:0]  br_mask;
   logic [63:0] br_target;
   logic        cmp_valid, cmp_lt, cmp_gt;
   logic        mode_ea, mode_ba;
   logic [7:0]  exc_code;
   logic [63:0] next_addr, fail_addr;
   logic [1:0]  cc_out;
   logic        spec_exc;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   insn_addr_seq u_insn_addr_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_en   (step_en),
      .ilen      (ilen),
      .is_branch (is_branch),
      .br_mask   (br_mask),
      .br_target (br_target),
      .cmp_valid (cmp_valid),
      .cmp_lt    (cmp_lt),
      .cmp_gt    (cmp_gt),
      .mode_ea   (mode_ea),
      .mode_ba   (mode_ba),
      .exc_code  (exc_code),
      .next_addr (next_addr),
      .fail_addr (fail_addr),
      .cc_out    (cc_out),
      .spec_exc  (spec_exc)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic st, input logic [3:0] l, input logic br, input logic [3:0] m,
                        input logic [63:0] t, input logic cv, input logic lt, input logic gt,
                        input logic ea, input logic ba, input logic [7:0] ec);
      step_en = st; ilen = l; is_branch = br; br_mask = m; br_target = t;
      cmp_valid = cv; cmp_lt = lt; cmp_gt = gt; mode_ea = ea; mode_ba = ba; exc_code = ec;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      drive(1'b0, 4'd0, 1'b0, 4'b0, 64'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 addr", next_addr, 64'h0);
      chk("R1 cc", {62'd0, cc_out}, 64'd0);
      chk("R1 spec", {63'd0, spec_exc}, 64'd0);

      // Vector chain: R2 R3 R4 R5 R6 R7
      for (int i = 0; i < NVEC; i++) begin
         drive(1'b1, VECS[i].ilen, VECS[i].br, VECS[i].mask, VECS[i].tgt, VECS[i].cv,
               VECS[i].lt, VECS[i].gt, VECS[i].ea, VECS[i].ba, 8'h0);
         @(negedge clk);
         chk($sformatf("R2/R4/R6/R7 vec%0d addr", i), next_addr, VECS[i].exp_addr);
         chk($sformatf("R3/R4/R5 vec%0d cc", i), {62'd0, cc_out}, {62'd0, VECS[i].exp_cc});
      end

      // R12 idle step with live branch and compare inputs
      drive(1'b0, 4'd4, 1'b1, 4'b1111, 64'h9999, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h0);
      @(negedge clk);
      chk("R12 addr hold", next_addr, 64'h23_4566);
      chk("R12 cc hold", {62'd0, cc_out}, 64'd2);

      // R8 failing address, 64-bit mode
      drive(1'b0, 4'd6, 1'b0, 4'b0, 64'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
      #1 chk("R8 fail 64", fail_addr, 64'h23_4560);

      // R4 always-taken mask to address 2
      @(negedge clk);
      drive(1'b1, 4'd2, 1'b1, 4'b1111, 64'h2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
      @(negedge clk);
      chk("R4 always taken", next_addr, 64'h2);

      // R8 wrap below zero in 31-bit mode, R9 translation codes
      drive(1'b0, 4'd4, 1'b0, 4'b0, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
      #1 chk("R8 fail wrap 31", fail_addr, 64'h7FFF_FFFE);
      exc_code = 8'h10;
      #1 chk("R9 fail seg code", fail_addr, 64'h2);
      exc_code = 8'h11;
      #1 chk("R9 fail page code", fail_addr, 64'h2);
      exc_code = 8'h12;
      #1 chk("R9 other code", fail_addr, 64'h7FFF_FFFE);

      // R10 invalid mode pair
      @(negedge clk);
      drive(1'b1, 4'd2, 1'b1, 4'b1111, 64'h800, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
      #1 chk("R10 spec flag", {63'd0, spec_exc}, 64'd1);
      @(negedge clk);
      chk("R10 addr hold", next_addr, 64'h2);
      chk("R10 cc hold", {62'd0, cc_out}, 64'd2);

      // R11 illegal lengths
      drive(1'b1, 4'd3, 1'b1, 4'b1111, 64'h100, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
      #1 chk("R11 spec len3", {63'd0, spec_exc}, 64'd1);
      @(negedge clk);
      chk("R11 addr hold len3", next_addr, 64'h2);
      chk("R11 cc hold len3", {62'd0, cc_out}, 64'd2);
      drive(1'b1, 4'd8, 1'b0, 4'b0, 64'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
      #1 chk("R11 spec len8", {63'd0, spec_exc}, 64'd1);
      @(negedge clk);
      chk("R11 addr hold len8", next_addr, 64'h2);
      drive(1'b1, 4'd0, 1'b0, 4'b0, 64'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
      #1 chk("R11 spec len0", {63'd0, spec_exc}, 64'd1);
      @(negedge clk);
      chk("R11 addr hold len0", next_addr, 64'h2);

      // R2 legal step clears flag
      drive(1'b1, 4'd6, 1'b0, 4'b0, 64'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
      #1 chk("R2 no spec on legal step", {63'd0, spec_exc}, 64'd0);
      @(negedge clk);
      chk("R2 advance after reject", next_addr, 64'h8);
      step_en = 1'b0;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule